// File: doc/BRIEF.md
# Direct-Mapped Byte Cache Controller

This block places a direct-mapped cache between a processor port and a slower main-memory port. Both ports use a 20-bit byte address. The cache holds 1024 lines of 16 bytes. Each line keeps a tag, a valid flag and a dirty flag. The processor issues single-byte reads and writes with a request/acknowledge handshake. The acknowledge is held back until the access is finished, whether that access hits, needs a line fill, or waits on a write to memory.

On a miss the controller first writes back the victim line if it is dirty. It then refills the whole line, one byte per memory beat, and serves the access from the refreshed line. Writes allocate on a miss. A mode input chosen per request selects the write policy:

- **Write-back:** a write touches only the cache and marks the line dirty.
- **Write-through:** a write updates the cache and also performs one memory write beat before the acknowledge.

Top module: `dm_cache_ctrl`

## Requirements
- R1: The byte address splits into tag = addr[19:14], line index = addr[13:4] and byte offset = addr[3:0]. Two addresses with the same index and different tags compete for the same single line.
- R2: After reset every line is invalid, `cpu_ack` and `mem_req` are low, and the first access to any line is a miss.
- R3: A read that hits returns the stored byte on `cpu_rdata` during the single `cpu_ack` cycle, with no memory beat.
- R4: A miss on a line that is invalid or clean produces exactly 16 read beats. The beats go to {new tag, index, 0..15} in ascending offset order. The requested byte is then returned from the refilled line.
- R5: In write-back mode (`wt_mode`=0), a write that hits updates only the cache and marks the line dirty. Main memory at that address is left unchanged.
- R6: A miss on a valid dirty line first issues 16 write beats of the old line's bytes to {old tag, index, 0..15} in ascending order. The 16 read beats of the fill follow.
- R7: In write-through mode (`wt_mode`=1), a write updates the cache and issues exactly one write beat of the byte to its own address. `cpu_ack` comes only after that beat completes, and the line is not marked dirty.
- R8: `wt_mode` is sampled with each request. A line made dirty in write-back mode is still written back on eviction when the evicting request uses write-through mode.
- R9: `cpu_ack` is a one-cycle pulse per request. While `mem_req` is high without `mem_ack`, `mem_addr`, `mem_we` and `mem_wdata` stay stable into the next cycle.
- R10: A write that misses first brings the line in (with a write-back if it is dirty). The write is then applied under the selected policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back; held with the request |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 20 | Processor byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ack` is high |
| mem_req | output | 1 | Memory beat request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write beat, 0 = read beat |
| mem_addr | output | 20 | Memory byte address of the beat |
| mem_wdata | output | 8 | Byte written by a write beat |
| mem_ack | input | 1 | One-cycle beat completion; read data valid with it |
| mem_rdata | input | 8 | Byte returned by a read beat |

## Verification
The most delicate same-cycle coincidences both happen at the end of a burst.

- **Eviction to fill:** the last write-back beat is acknowledged on the same edge where the beat counter wraps and the fill begins. The first fill beat must follow at offset 0 with no gap.
- **Fill to write:** the last fill beat installs the tag and valid flag on the same edge that stores the final byte. The re-lookup on the next cycle must hit. If the request is a write, it must then overlay the new line, and in write-through mode it must also start its memory beat.

The bench provokes both coincidences constantly:

- It draws random tags and indexes from a small pool with random directions and modes.
- It uses a memory model with random wait states.
- It adds directed mode switches on dirty lines and the boundary line 1023 with tag 63.

Every request is judged three ways:

- The logged memory beat sequence is compared with one the bench predicts from its own tag/valid/dirty shadow.
- Read data is checked against a flat reference memory.
- Main memory contents are checked after each write.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int DEF_TAG_W  = 6;
    localparam int DEF_IDX_W  = 10;
    localparam int DEF_OFF_W  = 4;
    localparam int DEF_ADDR_W = DEF_TAG_W + DEF_IDX_W + DEF_OFF_W;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU,
        ST_RESP
    } ctl_state_e;

    function automatic logic is_burst(input ctl_state_e s);
        return (s == ST_EVICT) || (s == ST_FILL);
    endfunction
endpackage

// File: rtl/cache_beat_ctr.sv
module cache_beat_ctr #(
    parameter int CNT_W = cache_pkg::DEF_OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == {CNT_W{1'b1}});
endmodule

// File: rtl/cache_arrays.sv
module cache_arrays #(
    parameter int TAG_W  = cache_pkg::DEF_TAG_W,
    parameter int IDX_W  = cache_pkg::DEF_IDX_W,
    parameter int OFF_W  = cache_pkg::DEF_OFF_W,
    parameter int BYTE_W = cache_pkg::DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              byte_we,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [BYTE_W-1:0] byte_din,
    input  logic              mark_dirty,
    input  logic              install,
    input  logic [TAG_W-1:0]  install_tag
);
    localparam int LINES  = 1 << IDX_W;
    localparam int BYTES  = 1 << OFF_W;
    localparam int LINE_W = BYTES * BYTE_W;

    logic [LINE_W-1:0] data_q [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    // flags need reset; payload arrays do not
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (byte_we) begin
            data_q[idx][int'(byte_off)*BYTE_W +: BYTE_W] <= byte_din;
        end
        if (install) begin
            tag_q[idx] <= install_tag;
        end
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_byte  = data_q[idx][int'(rd_off)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int TAG_W  = DEF_TAG_W,
    parameter int IDX_W  = DEF_IDX_W,
    parameter int OFF_W  = DEF_OFF_W,
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wt_mode,
    input  logic                           cpu_req,
    input  logic                           cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]   cpu_addr,
    input  logic [BYTE_W-1:0]              cpu_wdata,
    output logic                           cpu_ack,
    output logic [BYTE_W-1:0]              cpu_rdata,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]              mem_wdata,
    input  logic                           mem_ack,
    input  logic [BYTE_W-1:0]              mem_rdata,
    // array side
    output logic [IDX_W-1:0]               arr_idx,
    output logic [OFF_W-1:0]               arr_rd_off,
    input  logic [TAG_W-1:0]               arr_tag,
    input  logic                           arr_valid,
    input  logic                           arr_dirty,
    input  logic [BYTE_W-1:0]              arr_byte,
    output logic                           arr_byte_we,
    output logic [OFF_W-1:0]               arr_byte_off,
    output logic [BYTE_W-1:0]              arr_byte_din,
    output logic                           arr_mark_dirty,
    output logic                           arr_install,
    output logic [TAG_W-1:0]               arr_install_tag,
    // beat counter side
    input  logic [OFF_W-1:0]               beat,
    input  logic                           beat_last,
    output logic                           beat_clr,
    output logic                           beat_step,
    // observation for the checker
    output logic                           in_burst,
    output logic                           cmd_wt
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    ctl_state_e          state, nxt;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   wdata_q;
    logic                wt_q;
    logic [BYTE_W-1:0]   rdata_q;

    logic [ADDR_W-1:0]   cur_addr;
    logic [TAG_W-1:0]    cur_tag;
    logic [IDX_W-1:0]    cur_idx;
    logic [OFF_W-1:0]    cur_off;
    logic                hit;
    logic                load_cmd;
    logic                rdata_load;

    // live request while idle, latched one afterwards
    assign cur_addr = (state == ST_IDLE) ? cpu_addr : addr_q;
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_idx  = cur_addr[OFF_W +: IDX_W];
    assign cur_off  = cur_addr[OFF_W-1:0];
    assign hit      = arr_valid && (arr_tag == cur_tag);

    assign arr_idx         = cur_idx;
    assign arr_rd_off      = (state == ST_EVICT) ? beat : cur_off;
    assign arr_install_tag = cur_tag;

    always_comb begin
        nxt            = state;
        load_cmd       = 1'b0;
        rdata_load     = 1'b0;
        beat_clr       = 1'b0;
        beat_step      = 1'b0;
        arr_byte_we    = 1'b0;
        arr_byte_off   = cur_off;
        arr_byte_din   = cpu_wdata;
        arr_mark_dirty = 1'b0;
        arr_install    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    load_cmd = 1'b1;
                    if (hit) begin
                        if (cpu_we) begin
                            arr_byte_we = 1'b1;
                            if (wt_mode) begin
                                nxt = ST_WTHRU;
                            end else begin
                                arr_mark_dirty = 1'b1;
                                nxt            = ST_RESP;
                            end
                        end else begin
                            rdata_load = 1'b1;
                            nxt        = ST_RESP;
                        end
                    end else begin
                        beat_clr = 1'b1;
                        nxt      = (arr_valid && arr_dirty) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    beat_step = 1'b1;
                    if (beat_last) nxt = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    beat_step    = 1'b1;
                    arr_byte_we  = 1'b1;
                    arr_byte_off = beat;
                    arr_byte_din = mem_rdata;
                    if (beat_last) begin
                        arr_install = 1'b1;
                        nxt         = ST_IDLE;
                    end
                end
            end
            ST_WTHRU: begin
                if (mem_ack) nxt = ST_RESP;
            end
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wt_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (load_cmd) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
                wt_q    <= wt_mode;
            end
            if (rdata_load) begin
                rdata_q <= arr_byte;
            end
        end
    end

    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        unique case (state)
            ST_EVICT: begin
                mem_addr  = {arr_tag, cur_idx, beat};
                mem_wdata = arr_byte;
            end
            ST_FILL:  mem_addr = {cur_tag, cur_idx, beat};
            default:  ;
        endcase
    end

    assign mem_req   = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WTHRU);
    assign mem_we    = (state == ST_EVICT) || (state == ST_WTHRU);
    assign cpu_ack   = (state == ST_RESP);
    assign cpu_rdata = rdata_q;
    assign in_burst  = is_burst(state);
    assign cmd_wt    = wt_q;
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
    parameter int TAG_W  = cache_pkg::DEF_TAG_W,
    parameter int IDX_W  = cache_pkg::DEF_IDX_W,
    parameter int OFF_W  = cache_pkg::DEF_OFF_W,
    parameter int BYTE_W = cache_pkg::DEF_BYTE_W,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_rd_off;
    logic [TAG_W-1:0]  a_tag;
    logic              a_valid;
    logic              a_dirty;
    logic [BYTE_W-1:0] a_byte;
    logic              a_byte_we;
    logic [OFF_W-1:0]  a_byte_off;
    logic [BYTE_W-1:0] a_byte_din;
    logic              a_mark_dirty;
    logic              a_install;
    logic [TAG_W-1:0]  a_install_tag;
    logic [OFF_W-1:0]  beat;
    logic              beat_last;
    logic              beat_clr;
    logic              beat_step;
    logic              burst_w;
    logic              wt_w;

    cache_arrays #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)
    ) u_arrays (
        .clk        (clk),
        .rst        (rst),
        .idx        (a_idx),
        .rd_off     (a_rd_off),
        .rd_tag     (a_tag),
        .rd_valid   (a_valid),
        .rd_dirty   (a_dirty),
        .rd_byte    (a_byte),
        .byte_we    (a_byte_we),
        .byte_off   (a_byte_off),
        .byte_din   (a_byte_din),
        .mark_dirty (a_mark_dirty),
        .install    (a_install),
        .install_tag(a_install_tag)
    );

    cache_beat_ctr #(.CNT_W(OFF_W)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .clr  (beat_clr),
        .step (beat_step),
        .count(beat),
        .last (beat_last)
    );

    cache_ctrl #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .wt_mode        (wt_mode),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_ack        (cpu_ack),
        .cpu_rdata      (cpu_rdata),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .arr_idx        (a_idx),
        .arr_rd_off     (a_rd_off),
        .arr_tag        (a_tag),
        .arr_valid      (a_valid),
        .arr_dirty      (a_dirty),
        .arr_byte       (a_byte),
        .arr_byte_we    (a_byte_we),
        .arr_byte_off   (a_byte_off),
        .arr_byte_din   (a_byte_din),
        .arr_mark_dirty (a_mark_dirty),
        .arr_install    (a_install),
        .arr_install_tag(a_install_tag),
        .beat           (beat),
        .beat_last      (beat_last),
        .beat_clr       (beat_clr),
        .beat_step      (beat_step),
        .in_burst       (burst_w),
        .cmd_wt         (wt_w)
    );
endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
    parameter int ADDR_W = cache_pkg::DEF_ADDR_W,
    parameter int OFF_W  = cache_pkg::DEF_OFF_W,
    parameter int BYTE_W = cache_pkg::DEF_BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ack,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              in_burst,
    input logic              cmd_wt
);
    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!cpu_ack && !mem_req));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4 R6
    beat_order_chk: assert property (@(posedge clk) disable iff (rst)
        (in_burst && mem_req && mem_ack && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}}))
            |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));

    // R7
    single_write_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !in_burst) |-> cmd_wt);
endmodule

bind dm_cache_ctrl cache_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_ack  (cpu_ack),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .in_burst (burst_w),
    .cmd_wt   (wt_w)
);

// File: tb/test_dm_cache_ctrl.sv
module test_dm_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wt_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ack;
    logic [7:0]  cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int n_checks = 0;
    int n_errors = 0;
    int n_hits = 0;
    int n_misses = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dm_cache_ctrl i_dm_cache_ctrl (
        .clk(clk), .rst(rst), .wt_mode(wt_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model and reference ----------------
    logic [7:0]  mem_model [int];
    logic [7:0]  ref_mem   [int];
    logic [28:0] log_q [$];
    logic [28:0] exp_q [$];
    int          wait_cnt = 0;

    function automatic logic [7:0] init_byte(input int a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'hA};
    endfunction

    function automatic logic [7:0] mem_get(input int a);
        if (mem_model.exists(a)) return mem_model[a];
        return init_byte(a);
    endfunction

    function automatic logic [7:0] ref_get(input int a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return init_byte(a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
                else        mem_rdata <= mem_get(int'(mem_addr));
                log_q.push_back({mem_we, mem_addr, mem_wdata});
                mem_ack  <= 1'b1;
                wait_cnt <= $urandom_range(0, 2);
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    // ---------------- bench shadow of line state ----------------
    bit         sh_valid [1024];
    bit         sh_dirty [1024];
    logic [5:0] sh_tag   [1024];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic do_req(input bit we, input logic [19:0] a, input logic [7:0] d, input bit wt);
        logic [9:0] ix = a[13:4];
        logic [5:0] tg = a[19:14];
        bit         hit;
        bit         evict = 0;
        bit         ok;
        logic [7:0] pre;
        logic [31:0] act_v, exp_v;
        string      seq_lbl;

        exp_q.delete();
        hit = sh_valid[ix] && (sh_tag[ix] == tg);
        if (hit) n_hits++; else n_misses++;
        if (!hit) begin
            if (sh_valid[ix] && sh_dirty[ix]) begin
                evict = 1;
                for (int k = 0; k < 16; k++) begin
                    logic [19:0] ea = {sh_tag[ix], ix, 4'(k)};
                    exp_q.push_back({1'b1, ea, ref_get(int'(ea))});
                end
            end
            for (int k = 0; k < 16; k++) begin
                exp_q.push_back({1'b0, tg, ix, 4'(k), 8'h00});
            end
            sh_valid[ix] = 1;
            sh_tag[ix]   = tg;
            sh_dirty[ix] = 0;
        end
        if (we) begin
            if (wt) exp_q.push_back({1'b1, a, d});
            else    sh_dirty[ix] = 1;
        end
        if (evict)           seq_lbl = "R6";
        else if (!hit && we) seq_lbl = "R10";
        else if (!hit)       seq_lbl = "R4";
        else if (we && wt)   seq_lbl = "R7";
        else                 seq_lbl = "R3";

        pre = mem_get(int'(a));
        @(negedge clk);
        log_q.delete();
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        wt_mode   = wt;
        do @(negedge clk); while (!cpu_ack);

        if (!we) chk(cpu_rdata == ref_get(int'(a)), hit ? "R3" : "R4", "read data",
                     {24'h0, cpu_rdata}, {24'h0, ref_get(int'(a))});
        else ref_mem[int'(a)] = d;
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_ack, "R9", "ack pulse width", {31'h0, cpu_ack}, 32'h0);

        ok    = (log_q.size() == exp_q.size());
        act_v = log_q.size();
        exp_v = exp_q.size();
        if (ok) begin
            foreach (exp_q[i]) begin
                logic [28:0] e = exp_q[i];
                logic [28:0] g = log_q[i];
                bit mis = e[28] ? (e != g) : (e[28:8] != g[28:8]);
                if (mis && ok) begin
                    ok    = 0;
                    act_v = {3'b0, g};
                    exp_v = {3'b0, e};
                end
            end
        end
        chk(ok, seq_lbl, "memory beat sequence", act_v, exp_v);

        if (we && wt)  chk(mem_get(int'(a)) == d, "R7", "memory after write-through",
                           {24'h0, mem_get(int'(a))}, {24'h0, d});
        if (we && !wt) chk(mem_get(int'(a)) == pre, "R5", "memory untouched by write-back",
                           {24'h0, mem_get(int'(a))}, {24'h0, pre});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: quiet ports after reset
        chk(!cpu_ack, "R2", "cpu_ack after reset", {31'h0, cpu_ack}, 32'h0);
        chk(!mem_req, "R2", "mem_req after reset", {31'h0, mem_req}, 32'h0);

        // R2: first access to a line misses and fills (R4)
        do_req(0, 20'h00123, 8'h00, 0);
        do_req(0, 20'h00129, 8'h00, 0);       // R3 hit, no traffic
        do_req(1, 20'h00125, 8'h5A, 0);       // R5 write-back hit
        // R1: tag 1, same index 0x12 -> conflict, dirty eviction R6
        do_req(0, 20'h04123, 8'h00, 0);
        do_req(0, 20'h00125, 8'h00, 0);       // written-back byte returns
        do_req(1, 20'h00127, 8'hC3, 1);       // R7 write-through hit
        do_req(0, 20'h04120, 8'h00, 0);       // R7: line stayed clean, no write-back
        do_req(1, 20'h08340, 8'h11, 1);       // R10 write-through write miss
        do_req(1, 20'h0C340, 8'h22, 0);       // R10 write-back write miss
        // R8: dirty line evicted by a write-through-mode request
        do_req(0, 20'h10340, 8'h00, 1);
        // R1: boundary line 1023, tag 63
        do_req(1, 20'hFFFFF, 8'hEE, 0);
        do_req(0, 20'h3FFF0, 8'h00, 0);
        do_req(0, 20'hFFFFF, 8'h00, 0);

        // constrained random mix
        for (int n = 0; n < 1200; n++) begin
            int          r   = $urandom_range(0, 9);
            logic [9:0]  ix  = (r < 9) ? 10'(r) : 10'd1023;
            logic [5:0]  tg  = 6'($urandom_range(0, 3));
            logic [3:0]  off = 4'($urandom_range(0, 15));
            bit          we  = 1'($urandom_range(0, 1));
            bit          wt  = ($urandom_range(0, 9) < 3);
            logic [7:0]  d   = 8'($urandom);
            do_req(we, {tg, ix, off}, d, wt);
        end

        $display("hits=%0d misses=%0d", n_hits, n_misses);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule